// File: doc/BRIEF.md
# Dual-Segment Packet Bus Packer

This block takes a packet stream that arrives one 32-byte word at a time and lays it onto a 64-byte output bus. The output bus is split into two 32-byte segments: segment A, which holds the earlier bytes in the upper half of the bus, and segment B, which holds the later bytes in the lower half. Each segment carries its own valid, start, end and empty-byte fields, so a downstream consumer can see where packets begin and end inside a beat.

Two packing modes are supported. In single-segment mode every packet starts in segment A of a fresh beat. A packet that ends in segment A leaves segment B empty. In dual-segment mode, a packet that ends in segment A may be followed in the same beat by the first word of the next packet in segment B, so back-to-back traffic fills every beat. The mode is taken from the `dual_mode` input when a packet's first word is accepted, and it holds for the whole packet.

Both sides use ready/valid flow control. A one-word holding stage collects segment A, and a registered output stage presents each complete beat until it is taken.

Top module: `seg_pack_bus`

## Requirements
- R1: During and right after reset, `out_valid` and all segment flags are 0, and `in_ready` is 1.
- R2: A beat places the first input word it contains on `out_data[511:256]` (segment A) and the second on `out_data[255:0]` (segment B), with each word's bits unchanged.
- R3: In single-segment mode, each packet starts in segment A. Its words fill beats two at a time, so a packet of N words uses ceil(N/2) beats. When N is odd, segment B of the last beat is invalid.
- R4: In dual-segment mode, when a packet ends in segment A and the next input word is already offered in that cycle as the first word of a dual-segment packet, that word is placed in segment B of the same beat.
- R5: The mode is sampled only with a packet's first word (`in_sop`=1). `dual_mode` values seen with later words of the packet have no effect. A packet may share a beat with the one before it only if both were accepted in dual-segment mode.
- R6: For each segment, start and end flags are copied from the word placed there. The empty count equals the word's `in_empty` when the word ends a packet and is 0 otherwise. A segment whose valid is 0 drives its start, end, empty and data to 0.
- R7: While `out_valid`=1 and `out_ready`=0, the output bus and all segment fields stay unchanged on the next cycle.
- R8: `in_ready` is 0 only when segment A is already held and the output stage holds a beat that is not being taken (`out_valid`=1 and `out_ready`=0).
- R9: Whenever `out_valid`=1, segment A is valid. Segment B is valid only together with segment A.
- R10: When a dual-segment packet's last word waits in segment A and no input word is offered, the beat is issued with segment B invalid. It appears two clock edges after that word was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dual_mode | input | 1 | 1 selects dual-segment packing for a packet starting now |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word can be taken |
| in_data | input | 256 | Input word, byte 0 in bits 255:248 |
| in_sop | input | 1 | Word is the first of a packet |
| in_eop | input | 1 | Word is the last of a packet |
| in_empty | input | 5 | Unused trailing bytes of an end word |
| out_valid | output | 1 | A beat is presented |
| out_ready | input | 1 | Consumer takes the beat |
| out_data | output | 512 | Beat data, segment A in 511:256 |
| out_a_valid | output | 1 | Segment A holds data |
| out_a_sop | output | 1 | Segment A starts a packet |
| out_a_eop | output | 1 | Segment A ends a packet |
| out_a_empty | output | 5 | Unused trailing bytes of segment A |
| out_b_valid | output | 1 | Segment B holds data |
| out_b_sop | output | 1 | Segment B starts a packet |
| out_b_eop | output | 1 | Segment B ends a packet |
| out_b_empty | output | 5 | Unused trailing bytes of segment B |

## Verification
A paired beat is loaded into the output stage on the same edge that accepts its second word. A beat that ends in segment A is loaded on the edge after its word was accepted, so it becomes visible two edges after acceptance. The bench drives inputs on the falling edge and samples one nanosecond later, when every registered output and the combinational `in_ready` have settled for the next rising edge. Beats are compared in order at each cycle where `out_valid` and `out_ready` are both high, so checks stay aligned for any backpressure pattern. Two directed single-word packets check the exact two-edge delay of a lone segment-A beat in each mode.

// File: rtl/seg_pack_pkg.sv
package seg_pack_pkg;

    localparam int unsigned DEF_SEG_BYTES = 32;

    // width of a count that indexes bytes within a segment
    function automatic int unsigned cnt_w(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/seg_pack_mode_track.sv
module seg_pack_mode_track (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic sop,
    input  logic dual_req,
    output logic word_dual
);

    typedef struct packed {
        logic dual;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d     = trk_q;
        // mode request is honoured only on the first word of a packet
        word_dual = sop ? dual_req : trk_q.dual;
        if (take) begin
            trk_d.dual = word_dual;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

endmodule

// File: rtl/seg_pack_lane_gate.sv
module seg_pack_lane_gate #(
    parameter int unsigned SEG_W   = 256,
    parameter int unsigned EMPTY_W = 5
) (
    input  logic               valid,
    input  logic [SEG_W-1:0]   data_i,
    input  logic               sop_i,
    input  logic               eop_i,
    input  logic [EMPTY_W-1:0] empty_i,
    output logic [SEG_W-1:0]   data_o,
    output logic               sop_o,
    output logic               eop_o,
    output logic [EMPTY_W-1:0] empty_o
);

    always_comb begin
        data_o  = valid ? data_i : '0;
        sop_o   = valid & sop_i;
        eop_o   = valid & eop_i;
        empty_o = (valid && eop_i) ? empty_i : '0;
    end

endmodule

// File: rtl/seg_pack_out_stage.sv
module seg_pack_out_stage #(
    parameter int unsigned SEG_W   = 256,
    parameter int unsigned EMPTY_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 ready,
    input  logic [1:0]           seg_valid_i,
    input  logic [2*SEG_W-1:0]   data_i,
    input  logic [1:0]           sop_i,
    input  logic [1:0]           eop_i,
    input  logic [2*EMPTY_W-1:0] empty_i,
    output logic                 valid_o,
    output logic [1:0]           seg_valid_o,
    output logic [2*SEG_W-1:0]   data_o,
    output logic [1:0]           sop_o,
    output logic [1:0]           eop_o,
    output logic [2*EMPTY_W-1:0] empty_o
);

    typedef struct packed {
        logic                 valid;
        logic [1:0]           seg_valid;
        logic [2*SEG_W-1:0]   data;
        logic [1:0]           sop;
        logic [1:0]           eop;
        logic [2*EMPTY_W-1:0] empty;
    } beat_t;

    beat_t beat_d, beat_q;

    always_comb begin
        beat_d = beat_q;
        if (load) begin
            beat_d.valid     = 1'b1;
            beat_d.seg_valid = seg_valid_i;
            beat_d.data      = data_i;
            beat_d.sop       = sop_i;
            beat_d.eop       = eop_i;
            beat_d.empty     = empty_i;
        end else if (ready) begin
            beat_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else begin
            beat_q <= beat_d;
        end
    end

    assign valid_o     = beat_q.valid;
    assign seg_valid_o = beat_q.seg_valid;
    assign data_o      = beat_q.data;
    assign sop_o       = beat_q.sop;
    assign eop_o       = beat_q.eop;
    assign empty_o     = beat_q.empty;

endmodule

// File: rtl/seg_pack_bus.sv
module seg_pack_bus #(
    parameter int unsigned SEG_BYTES = seg_pack_pkg::DEF_SEG_BYTES,
    localparam int unsigned SEG_W    = SEG_BYTES * 8,
    localparam int unsigned BUS_W    = 2 * SEG_W,
    localparam int unsigned EMPTY_W  = seg_pack_pkg::cnt_w(SEG_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dual_mode,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [SEG_W-1:0]   in_data,
    input  logic               in_sop,
    input  logic               in_eop,
    input  logic [EMPTY_W-1:0] in_empty,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [BUS_W-1:0]   out_data,
    output logic               out_a_valid,
    output logic               out_a_sop,
    output logic               out_a_eop,
    output logic [EMPTY_W-1:0] out_a_empty,
    output logic               out_b_valid,
    output logic               out_b_sop,
    output logic               out_b_eop,
    output logic [EMPTY_W-1:0] out_b_empty
);

    // lane index 1 is segment A (earlier bytes, upper half), 0 is segment B
    localparam int unsigned LANE_A = 1;
    localparam int unsigned LANE_B = 0;

    typedef struct packed {
        logic               full;
        logic               dual;
        logic [SEG_W-1:0]   data;
        logic               sop;
        logic               eop;
        logic [EMPTY_W-1:0] empty;
    } hold_t;

    hold_t hold_d, hold_q;

    logic               can_emit;
    logic               take_in;
    logic               word_dual;
    logic               close_a;
    logic               emit;
    logic               pair;

    logic [SEG_W-1:0]   lane_data_i  [2];
    logic               lane_sop_i   [2];
    logic               lane_eop_i   [2];
    logic [EMPTY_W-1:0] lane_empty_i [2];
    logic [1:0]         lane_valid;

    logic [BUS_W-1:0]   beat_data;
    logic [1:0]         beat_sop;
    logic [1:0]         beat_eop;
    logic [2*EMPTY_W-1:0] beat_empty;

    logic [1:0]         seg_valid_q;
    logic [1:0]         sop_q;
    logic [1:0]         eop_q;
    logic [2*EMPTY_W-1:0] empty_q;

    // the output stage can accept a new beat this cycle
    assign can_emit = !out_valid || out_ready;
    // input stalls only when segment A is occupied and the beat cannot leave
    assign in_ready = !hold_q.full || can_emit;
    assign take_in  = in_valid && in_ready;

    seg_pack_mode_track u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take_in),
        .sop      (in_sop),
        .dual_req (dual_mode),
        .word_dual(word_dual)
    );

    // a held end word closes its beat unless the next dual packet can join it
    assign close_a = hold_q.eop && !(hold_q.dual && in_valid && word_dual);

    always_comb begin
        hold_d = hold_q;
        emit   = 1'b0;
        pair   = 1'b0;
        if (hold_q.full) begin
            if (can_emit) begin
                if (close_a) begin
                    emit        = 1'b1;
                    hold_d.full = take_in;
                    if (take_in) begin
                        hold_d.dual  = word_dual;
                        hold_d.data  = in_data;
                        hold_d.sop   = in_sop;
                        hold_d.eop   = in_eop;
                        hold_d.empty = in_empty;
                    end
                end else if (in_valid) begin
                    emit        = 1'b1;
                    pair        = 1'b1;
                    hold_d.full = 1'b0;
                end
            end
        end else if (take_in) begin
            hold_d.full  = 1'b1;
            hold_d.dual  = word_dual;
            hold_d.data  = in_data;
            hold_d.sop   = in_sop;
            hold_d.eop   = in_eop;
            hold_d.empty = in_empty;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    // lane sources: A from the holding stage, B straight from the input
    always_comb begin
        lane_data_i[LANE_A]  = hold_q.data;
        lane_sop_i[LANE_A]   = hold_q.sop;
        lane_eop_i[LANE_A]   = hold_q.eop;
        lane_empty_i[LANE_A] = hold_q.empty;
        lane_data_i[LANE_B]  = in_data;
        lane_sop_i[LANE_B]   = in_sop;
        lane_eop_i[LANE_B]   = in_eop;
        lane_empty_i[LANE_B] = in_empty;
        lane_valid[LANE_A]   = emit;
        lane_valid[LANE_B]   = pair;
    end

    for (genvar g = 0; g < 2; g++) begin : g_lane
        seg_pack_lane_gate #(
            .SEG_W  (SEG_W),
            .EMPTY_W(EMPTY_W)
        ) u_gate (
            .valid  (lane_valid[g]),
            .data_i (lane_data_i[g]),
            .sop_i  (lane_sop_i[g]),
            .eop_i  (lane_eop_i[g]),
            .empty_i(lane_empty_i[g]),
            .data_o (beat_data[g*SEG_W +: SEG_W]),
            .sop_o  (beat_sop[g]),
            .eop_o  (beat_eop[g]),
            .empty_o(beat_empty[g*EMPTY_W +: EMPTY_W])
        );
    end

    seg_pack_out_stage #(
        .SEG_W  (SEG_W),
        .EMPTY_W(EMPTY_W)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (emit),
        .ready      (out_ready),
        .seg_valid_i(lane_valid),
        .data_i     (beat_data),
        .sop_i      (beat_sop),
        .eop_i      (beat_eop),
        .empty_i    (beat_empty),
        .valid_o    (out_valid),
        .seg_valid_o(seg_valid_q),
        .data_o     (out_data),
        .sop_o      (sop_q),
        .eop_o      (eop_q),
        .empty_o    (empty_q)
    );

    assign out_a_valid = seg_valid_q[LANE_A];
    assign out_a_sop   = sop_q[LANE_A];
    assign out_a_eop   = eop_q[LANE_A];
    assign out_a_empty = empty_q[LANE_A*EMPTY_W +: EMPTY_W];
    assign out_b_valid = seg_valid_q[LANE_B];
    assign out_b_sop   = sop_q[LANE_B];
    assign out_b_eop   = eop_q[LANE_B];
    assign out_b_empty = empty_q[LANE_B*EMPTY_W +: EMPTY_W];

endmodule

// File: rtl/seg_pack_bus_chk.sv
module seg_pack_bus_chk #(
    parameter int unsigned SEG_BYTES = seg_pack_pkg::DEF_SEG_BYTES,
    localparam int unsigned BUS_W    = SEG_BYTES * 16,
    localparam int unsigned EMPTY_W  = seg_pack_pkg::cnt_w(SEG_BYTES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_ready,
    input logic               out_valid,
    input logic               out_ready,
    input logic [BUS_W-1:0]   out_data,
    input logic               out_a_valid,
    input logic               out_a_sop,
    input logic               out_a_eop,
    input logic [EMPTY_W-1:0] out_a_empty,
    input logic               out_b_valid,
    input logic               out_b_sop,
    input logic               out_b_eop
);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
            && $stable(out_a_eop) && $stable(out_b_valid) && $stable(out_b_eop));

    p_stall_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> out_valid && !out_ready);

    p_seg_a_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_a_valid);

    p_seg_b_needs_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_b_valid |-> out_valid && out_a_valid);

    p_idle_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_b_valid |-> !out_b_sop && !out_b_eop);

    p_empty_only_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_a_eop |-> out_a_empty == '0);

    // a packet may open in segment B only behind an end in segment A
    p_b_start_after_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_b_sop |-> out_a_eop);

    // a continuing word in segment B belongs to the packet in segment A
    p_b_continue_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_b_valid && !out_b_sop |-> !out_a_eop);

endmodule

bind seg_pack_bus seg_pack_bus_chk #(.SEG_BYTES(SEG_BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_a_valid(out_a_valid),
    .out_a_sop  (out_a_sop),
    .out_a_eop  (out_a_eop),
    .out_a_empty(out_a_empty),
    .out_b_valid(out_b_valid),
    .out_b_sop  (out_b_sop),
    .out_b_eop  (out_b_eop)
);

// File: tb/seg_pack_bus_test.sv
module seg_pack_bus_test;

    localparam int SW    = 256;
    localparam int BW    = 512;
    localparam int EW    = 5;
    localparam int NPKT  = 40;
    localparam int MAXW  = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dual_mode = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [SW-1:0] in_data = '0;
    logic          in_sop = 1'b0;
    logic          in_eop = 1'b0;
    logic [EW-1:0] in_empty = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [BW-1:0] out_data;
    logic          out_a_valid, out_a_sop, out_a_eop;
    logic [EW-1:0] out_a_empty;
    logic          out_b_valid, out_b_sop, out_b_eop;
    logic [EW-1:0] out_b_empty;

    int checks = 0;
    int errors = 0;

    logic [7:0]    w_pkt  [MAXW];
    logic [7:0]    w_idx  [MAXW];
    bit            w_sop  [MAXW];
    bit            w_eop  [MAXW];
    logic [EW-1:0] w_emp  [MAXW];
    bit            w_dual [MAXW];
    int            n_words;
    int            ea [MAXW];
    int            eb [MAXW];
    int            n_beats;
    logic [15:0]   lf = 16'hACE1;

    always #2 clk = ~clk;

    seg_pack_bus uut (
        .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop), .in_empty(in_empty),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_a_valid(out_a_valid), .out_a_sop(out_a_sop), .out_a_eop(out_a_eop),
        .out_a_empty(out_a_empty), .out_b_valid(out_b_valid), .out_b_sop(out_b_sop),
        .out_b_eop(out_b_eop), .out_b_empty(out_b_empty)
    );

    task automatic chk(input bit ok, input string req, input logic [BW-1:0] act,
                       input logic [BW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [SW-1:0] wd(input int k);
        return {16{w_pkt[k], w_idx[k]}};
    endfunction

    task automatic step_lf();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    endtask

    // cfg 0: all single, 1: all dual, 2: mixed per packet
    task automatic build(input int cfg);
        int n;
        n = 0;
        for (int p = 0; p < NPKT; p++) begin
            int len;
            bit d;
            len = (p % 5) + 1;
            d = (cfg == 1) || (cfg == 2 && (p % 3) != 0);
            for (int k = 0; k < len; k++) begin
                w_pkt[n]  = 8'(p + 16 * cfg);
                w_idx[n]  = 8'(k);
                w_sop[n]  = (k == 0);
                w_eop[n]  = (k == len - 1);
                w_emp[n]  = EW'((p * 7 + 3) % 32);
                w_dual[n] = d;
                n++;
            end
        end
        n_words = n;
        n_beats = 0;
        for (int i = 0; i < n_words; ) begin
            ea[n_beats] = i;
            if (w_eop[i] && !(w_dual[i] && i + 1 < n_words && w_dual[i + 1])) begin
                eb[n_beats] = -1;
                i++;
            end else begin
                eb[n_beats] = i + 1;
                i += 2;
            end
            n_beats++;
        end
    endtask

    task automatic cmp_beat(input int b, input int cfg);
        int a, s;
        string pk;
        a = ea[b];
        s = eb[b];
        pk = (cfg == 2) ? "R5" : (w_dual[a] ? "R4" : "R3");
        chk(out_data[BW-1:SW] == wd(a), "R2 segment A data", out_data[BW-1:SW], wd(a));
        chk(out_a_valid && out_a_sop == w_sop[a] && out_a_eop == w_eop[a],
            "R6 segment A flags", {out_a_valid, out_a_sop, out_a_eop},
            {1'b1, w_sop[a], w_eop[a]});
        chk(out_a_empty == (w_eop[a] ? w_emp[a] : '0), "R6 segment A empty",
            out_a_empty, w_eop[a] ? w_emp[a] : '0);
        chk(out_b_valid == (s >= 0), {pk, " segment B occupancy"}, out_b_valid, s >= 0);
        if (s >= 0) begin
            chk(out_data[SW-1:0] == wd(s), "R2 segment B data", out_data[SW-1:0], wd(s));
            chk(out_b_sop == w_sop[s] && out_b_eop == w_eop[s] &&
                out_b_empty == (w_eop[s] ? w_emp[s] : '0), "R6 segment B fields",
                {out_b_sop, out_b_eop, out_b_empty},
                {w_sop[s], w_eop[s], w_eop[s] ? w_emp[s] : 5'd0});
        end else begin
            chk(out_data[SW-1:0] == '0 && !out_b_sop && !out_b_eop && out_b_empty == '0,
                "R6 idle segment B zeroed", {out_b_sop, out_b_eop, out_data[SW-1:0]}, '0);
        end
    endtask

    task automatic run(input int cfg, input bit bp);
        int i, b, cyc;
        bit prev_hold;
        logic [BW-1:0] saved;
        logic saved_eop;
        build(cfg);
        i = 0; b = 0; cyc = 0; prev_hold = 1'b0; saved = '0; saved_eop = 1'b0;
        while (b < n_beats && cyc < 20000) begin
            @(negedge clk);
            if (prev_hold) begin
                chk(out_valid && out_data == saved && out_a_eop == saved_eop,
                    "R7 beat held under backpressure", out_data, saved);
            end
            step_lf();
            out_ready = bp ? (lf[0] | lf[3]) : 1'b1;
            if (i < n_words) begin
                in_valid = 1'b1;
                in_data  = wd(i);
                in_sop   = w_sop[i];
                in_eop   = w_eop[i];
                in_empty = w_emp[i];
                // later words of a packet get a random mode request (R5)
                dual_mode = w_sop[i] ? w_dual[i] : lf[5];
            end else begin
                in_valid = 1'b0;
            end
            #1;
            if (!in_ready) begin
                chk(out_valid && !out_ready, "R8 stall cause", {out_valid, out_ready}, 2'b10);
            end
            if (out_valid) begin
                chk(out_a_valid, "R9 segment A valid in beat", out_a_valid, 1'b1);
            end
            if (out_b_valid) begin
                chk(out_valid && out_a_valid, "R9 segment B needs A",
                    {out_valid, out_a_valid}, 2'b11);
            end
            if (out_valid && out_ready) begin
                cmp_beat(b, cfg);
                b++;
            end
            prev_hold = out_valid && !out_ready;
            saved = out_data;
            saved_eop = out_a_eop;
            if (in_valid && in_ready) i++;
            cyc++;
        end
        chk(b == n_beats, "R3 all beats delivered", b, n_beats);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // one-word packet; lone segment-A beat due two edges after acceptance
    task automatic lone_word(input bit dual, input string req);
        @(negedge clk);
        out_ready = 1'b1;
        dual_mode = dual;
        in_valid  = 1'b1;
        in_data   = {32{8'h5A}};
        in_sop    = 1'b1;
        in_eop    = 1'b1;
        in_empty  = 5'd3;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk(!out_valid, {req, " not early"}, out_valid, 1'b0);
        @(posedge clk);
        @(negedge clk);
        #1;
        chk(out_valid && out_a_valid && !out_b_valid && out_a_eop && out_a_empty == 5'd3 &&
            out_data[BW-1:SW] == {32{8'h5A}}, {req, " lone beat"},
            {out_valid, out_a_valid, out_b_valid, out_a_empty}, {3'b110, 5'd3});
        @(posedge clk);
        @(negedge clk);
        #1;
        chk(!out_valid, {req, " beat drained"}, out_valid, 1'b0);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk(!out_valid && !out_a_valid && !out_b_valid && in_ready, "R1 reset state",
            {out_valid, out_a_valid, out_b_valid, in_ready}, 4'b0001);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!out_valid && in_ready, "R1 after reset", {out_valid, in_ready}, 2'b01);
        lone_word(1'b0, "R3");
        lone_word(1'b1, "R10");
        for (int cfg = 0; cfg < 3; cfg++) begin
            run(cfg, 1'b0);
            run(cfg, 1'b1);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule